// File: doc/BRIEF.md
# Adder/Subtractor Condition Flag Unit

This block pairs a parameterised two's-complement adder/subtractor with the logic that derives the four arithmetic condition flags: negative, zero, carry and overflow. It also holds those flags in a status register. An execution stage presents two operands and a two-bit operation code. The block then returns the arithmetic result and a strobe that says whether that result should be written back. The registered flags stay available to later branch logic.

Four operations are supported. There is a plain add and a plain subtract. There is a compare, which subtracts only to refresh the flags and never requests a write-back. There is also a subtract that updates the flags. For subtraction, carry is reported as the inverse of a borrow. The result and the strobe are purely combinational. The flags appear at the status output one clock after a qualifying edge.

Top module: `alu_flag_unit`

## Requirements
- R1: `result` equals `opa + opb` modulo 2^WIDTH when `op` is 2'b00 (add), and `opa - opb` modulo 2^WIDTH for 2'b01 (subtract), 2'b10 (compare) and 2'b11 (subtract with flags), in the same cycle.
- R2: The negative flag equals the top bit of the result. The zero flag is 1 exactly when every result bit is 0. Zero and negative are never both 1.
- R3: On add, the carry flag is the carry out of the most significant bit (8-bit 0x7F+0x01 gives C=0; 0x80+0x80 gives C=1).
- R4: On any subtracting operation, the carry flag is 1 when no borrow occurs, that is when `opa >= opb` unsigned (8-bit 0x00-0x01 gives C=0, N=1, Z=0).
- R5: Overflow is set only when the effective operands (opa and opb for add, opa and the negated opb for subtract) share a sign and the result's sign differs from it. An add of operands with opposite signs never sets overflow.
- R6: `res_we` is 0 when `op` is compare (2'b10) and 1 for every other operation.
- R7: On a rising clock edge with `flag_we` high and `op` not equal to plain subtract (2'b01), `status` loads {N,Z,C,V}: bit 3 N, bit 2 Z, bit 1 C, bit 0 V.
- R8: `status` resets to 4'b0000 and holds its value on every edge where the R7 load condition is false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 2 | Operation code: 00 add, 01 subtract, 10 compare, 11 subtract with flags |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| flag_we | input | 1 | Permits a status update on this edge |
| result | output | WIDTH | Combinational arithmetic result |
| res_we | output | 1 | Result write-back strobe |
| status | output | 4 | Registered flags {N,Z,C,V} |

## Verification
`result` and `res_we` depend only on the current inputs and are due in the cycle the stimulus is applied. The bench drives inputs on the falling edge and samples these two outputs 1 ns later, before the next rising edge. `status` passes through one register, so it is due right after the next rising edge. It is sampled at the following falling edge. Hold and reset checks sample `status` at that same point, after an edge on which no load is allowed.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
   typedef enum logic [1:0] {
      OP_ADD  = 2'b00,
      OP_SUB  = 2'b01,
      OP_CMP  = 2'b10,
      OP_SUBS = 2'b11
   } alu_op_e;

   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic [WIDTH-1:0] b_eff
);
   initial begin
      if (WIDTH < 2) $error("alu_addsub: WIDTH must be at least 2");
   end

   assign b_eff = b ^ {WIDTH{sub}};

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = sub;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
         end
         assign cout = cy[WIDTH];
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
         assign sum  = wide[WIDTH-1:0];
         assign cout = wide[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/alu_flag_calc.sv
module alu_flag_calc
   import alu_flag_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b_eff,
   input  logic [WIDTH-1:0] sum,
   input  logic             cout,
   output flags_t           flags
);
   localparam int MSB = WIDTH - 1;

   always_comb begin
      flags.n = sum[MSB];
      flags.z = (sum == '0);
      flags.c = cout;
      flags.v = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
   end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_flag_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load,
   input  flags_t d,
   output flags_t q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(d)))
      else $error("status did not capture flags");

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q))
      else $error("status changed without load");

   p_z_excludes_n_r2: assert property (@(posedge clk) disable iff (!rst_n)
      q.z |-> !q.n)
      else $error("zero and negative both set");
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_flag_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       op,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             flag_we,
   output logic [WIDTH-1:0] result,
   output logic             res_we,
   output logic [3:0]       status
);
   localparam int MSB = WIDTH - 1;

   initial begin
      if (WIDTH < 2 || WIDTH > 64) $error("alu_flag_unit: WIDTH out of range");
   end

   alu_op_e    op_e;
   logic       is_sub;
   logic       cout;
   logic [WIDTH-1:0] b_eff;
   flags_t     nxt_flags;
   flags_t     cur_flags;
   logic       flag_load;

   assign op_e      = alu_op_e'(op);
   assign is_sub    = (op_e != OP_ADD);
   assign res_we    = (op_e != OP_CMP);
   assign flag_load = flag_we && (op_e != OP_SUB);

   alu_addsub #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_addsub (
      .a(opa), .b(opb), .sub(is_sub), .sum(result), .cout(cout), .b_eff(b_eff)
   );

   alu_flag_calc #(.WIDTH(WIDTH)) u_calc (
      .a(opa), .b_eff(b_eff), .sum(result), .cout(cout), .flags(nxt_flags)
   );

   alu_flag_reg u_reg (
      .clk(clk), .rst_n(rst_n), .load(flag_load), .d(nxt_flags), .q(cur_flags)
   );

   assign status = cur_flags;

   p_cmp_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e == OP_CMP) |-> !res_we)
      else $error("compare requested write-back");

   p_sub_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_sub |-> (nxt_flags.c == (opa >= opb)))
      else $error("subtract carry is not inverse borrow");

   p_mixed_sign_add_no_v_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_e == OP_ADD) && (opa[MSB] != opb[MSB])) |-> !nxt_flags.v)
      else $error("overflow on mixed-sign add");
endmodule

// File: tb/sim_alu_flag_unit.sv
`timescale 1ns/100ps
module sim_alu_flag_unit;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] op = 2'b00;
   logic [W-1:0] opa = '0, opb = '0;
   logic flag_we = 1'b0;
   logic [W-1:0] result;
   logic res_we;
   logic [3:0] status;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   alu_flag_unit #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb),
      .flag_we(flag_we), .result(result), .res_we(res_we), .status(status)
   );

   // {op, a, b, expected result, expected res_we, expected {N,Z,C,V}}
   localparam int NV = 10;
   localparam logic [30:0] VEC [NV] = '{
      {2'b00, 8'h7F, 8'h01, 8'h80, 1'b1, 4'b1001},
      {2'b00, 8'h80, 8'h80, 8'h00, 1'b1, 4'b0111},
      {2'b11, 8'h00, 8'h01, 8'hFF, 1'b1, 4'b1000},
      {2'b10, 8'h05, 8'h05, 8'h00, 1'b0, 4'b0110},
      {2'b00, 8'h01, 8'hFF, 8'h00, 1'b1, 4'b0110},
      {2'b11, 8'h80, 8'h01, 8'h7F, 1'b1, 4'b0011},
      {2'b11, 8'h7F, 8'hFF, 8'h80, 1'b1, 4'b1001},
      {2'b10, 8'h03, 8'h07, 8'hFC, 1'b0, 4'b1000},
      {2'b00, 8'h40, 8'h40, 8'h80, 1'b1, 4'b1001},
      {2'b00, 8'hFF, 8'hFF, 8'hFE, 1'b1, 4'b1010}
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic apply(input logic [1:0] o, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic we);
      @(negedge clk);
      op = o; opa = a; opb = b; flag_we = we;
      #1;
   endtask

   initial begin : watchdog
      #100000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R8 reset value
      repeat (3) @(negedge clk);
      check("R8 reset", {28'd0, status}, 32'd0);
      rst_n = 1'b1;

      // R1 R2 R3 R4 R5 R6 R7 from the table
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][30:29], VEC[i][28:21], VEC[i][20:13], 1'b1);
         check("R1 result", {24'd0, result}, {24'd0, VEC[i][12:5]});
         check("R6 res_we", {31'd0, res_we}, {31'd0, VEC[i][4]});
         @(negedge clk);
         check("R2 R3 R4 R5 R7 flags", {28'd0, status}, {28'd0, VEC[i][3:0]});
      end

      // R8 hold with flag_we low: current status 1010
      apply(2'b00, 8'h00, 8'h00, 1'b0);
      check("R1 zero add", {24'd0, result}, 32'd0);
      @(negedge clk);
      check("R8 hold flag_we low", {28'd0, status}, 32'b1010);

      // R7 plain subtract never loads flags, still writes result
      apply(2'b01, 8'h00, 8'h01, 1'b1);
      check("R1 plain sub", {24'd0, result}, 32'hFF);
      check("R6 plain sub strobe", {31'd0, res_we}, 32'd1);
      @(negedge clk);
      check("R7 plain sub no flag load", {28'd0, status}, 32'b1010);

      // R4 equal operands subtract: no borrow
      apply(2'b11, 8'hA5, 8'hA5, 1'b1);
      @(negedge clk);
      check("R4 equal sub carry", {28'd0, status}, 32'b0110);

      // R5 mixed-sign add with large magnitudes
      apply(2'b00, 8'h7F, 8'h80, 1'b1);
      @(negedge clk);
      check("R5 mixed sign no V", {28'd0, status}, 32'b1000);

      // R8 reset clears again
      rst_n = 1'b0;
      #1;
      check("R8 async reset", {28'd0, status}, 32'd0);
      flag_we = 1'b0;

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule